// File: doc/BRIEF.md
# Packed Signed-Byte Arithmetic Right Shifter

This unit is a SIMD datapath element for an execution stage. It views the low 32 bits of a source word as four signed bytes and moves each byte right by the same amount. Each byte keeps its own sign. The amount is taken from the low three bits of a second operand.

A mode bit chooses between two results:

- **Truncation:** the discarded bits are simply dropped.
- **Round-half-up:** a one is added at the highest discarded bit position before the result is taken.

The four results are packed into the low half of a 64-bit result. The upper half is filled with the sign of the top lane's result. An optional output register adds one cycle of latency and a matching valid strobe.

Alongside the datapath sits a purely combinational instruction recognizer. It checks a 32-bit word against the two instruction layouts that select the truncating and rounding variants. It raises exactly one of three flags: truncating form, rounding form, or not recognized. No input combination raises any exception or error indication.

Top module: `byte_sar_unit`

## Requirements
- R1: In truncating mode (`round_mode`=0) each byte lane (bits 7..0, 15..8, 23..16, 31..24 of `src_word`) is shifted right arithmetically by the amount, its bit 7 filling the vacated positions, and lands in the same bit positions of `result`.
- R2: The shift amount is `amt_word[2:0]` read as unsigned 0..7; bits 31..3 of `amt_word` have no effect on `result`.
- R3: In rounding mode (`round_mode`=1) with a nonzero amount k, each lane result equals floor((v + 2^(k-1)) / 2^k) for the signed lane value v, taken from a 9-bit intermediate that cannot wrap (0x7F with k=1 gives 0x40).
- R4: With an amount of zero both modes pass every byte through unchanged.
- R5: `result[63:32]` are all copies of the sign of the top lane's result (1 when that result is negative).
- R6: With `REG_OUT`=1, `result` and `valid_out`=1 appear one clock after `valid_in` is sampled high; when `valid_in` is sampled low, `valid_out` goes low the next clock and `result` keeps its value.
- R7: First instruction layout: bits 31..26 equal `FORM_A_MAJOR` (default 000000); bits 10..0 equal to 00111001101 raise `dec_plain`, and 10111001101 raises `dec_round`.
- R8: Second instruction layout: bits 31..26 = 011111, bits 5..0 = 010011; bits 10..6 equal to 00110 raise `dec_plain`, and 00111 raises `dec_round`. Register fields at bits 25..11 are don't-care in both layouts.
- R9: Exactly one of `dec_plain`, `dec_round`, `dec_unknown` is high at any time; any word matching neither layout raises `dec_unknown`.
- R10: After reset with `REG_OUT`=1, `valid_out` is 0 and `result` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | Operands valid this cycle |
| src_word | input | 32 | Four packed signed bytes |
| amt_word | input | 32 | Shift operand; low 3 bits used |
| round_mode | input | 1 | 0 truncate, 1 round-half-up |
| instr_word | input | 32 | Instruction word to classify |
| valid_out | output | 1 | Result valid |
| result | output | 64 | Packed lanes plus sign fill |
| dec_plain | output | 1 | Word selects truncating form |
| dec_round | output | 1 | Word selects rounding form |
| dec_unknown | output | 1 | Word matches neither form |

## Verification
The assertions assume that `valid_in` and the operands are steady and known around each sampling edge, and that `valid_in` is low while reset is held. The bench meets this by driving every input on the falling edge and holding `valid_in` low during reset.

The stimulus sweeps every amount from 0 to 7 in both modes over a set of fixed and pseudo-random source words. The fixed words contain the byte values 0x00, 0x7F, 0x80 and 0xFF. The upper bits of the shift operand are filled with junk, so the checks also show that those bits are ignored.

Instruction words carry random register fields. Near-miss words differ from a valid encoding in one field only.

// File: rtl/byte_sar_pkg.sv
package byte_sar_pkg;
    typedef enum logic [1:0] {
        DK_NONE  = 2'd0,
        DK_PLAIN = 2'd1,
        DK_ROUND = 2'd2
    } dec_kind_t;

    localparam logic [10:0] LAYA_MINOR_PLAIN = 11'b00111001101;
    localparam logic [10:0] LAYA_MINOR_ROUND = 11'b10111001101;
    localparam logic [5:0]  LAYB_MAJOR       = 6'b011111;
    localparam logic [4:0]  LAYB_SUB_PLAIN   = 5'b00110;
    localparam logic [4:0]  LAYB_SUB_ROUND   = 5'b00111;
    localparam logic [5:0]  LAYB_FUNC        = 6'b010011;
endpackage

// File: rtl/byte_sar_lane.sv
module byte_sar_lane #(
    parameter int W   = 8,
    parameter int SHW = $clog2(W)
) (
    input  logic [W-1:0]   lane_in,
    input  logic [SHW-1:0] amt,
    input  logic           rnd,
    output logic [W-1:0]   lane_out,
    output logic           lane_neg
);
    logic signed [W:0] ext;
    logic signed [W:0] pre;
    logic signed [W:0] sum;
    logic [SHW-1:0]    amt_m1;
    logic [W-1:0]      trunc;

    always_comb begin
        ext    = $signed({lane_in[W-1], lane_in});
        amt_m1 = amt - SHW'(1);
        pre    = ext >>> amt_m1;
        sum    = pre + (W+1)'(1);
        trunc  = W'($signed(lane_in) >>> amt);
        if (rnd && (amt != '0)) begin
            lane_out = sum[W:1];
            lane_neg = sum[W];
        end else begin
            lane_out = trunc;
            lane_neg = trunc[W-1];
        end
    end
endmodule

// File: rtl/byte_sar_decode.sv
module byte_sar_decode
    import byte_sar_pkg::*;
#(
    parameter logic [5:0] FORM_A_MAJOR = 6'b000000
) (
    input  logic [31:0] instr,
    output dec_kind_t   kind
);
    always_comb begin
        kind = DK_NONE;
        if (instr[31:26] == FORM_A_MAJOR) begin
            if (instr[10:0] == LAYA_MINOR_PLAIN)      kind = DK_PLAIN;
            else if (instr[10:0] == LAYA_MINOR_ROUND) kind = DK_ROUND;
        end
        if ((instr[31:26] == LAYB_MAJOR) && (instr[5:0] == LAYB_FUNC)) begin
            if (instr[10:6] == LAYB_SUB_PLAIN)      kind = DK_PLAIN;
            else if (instr[10:6] == LAYB_SUB_ROUND) kind = DK_ROUND;
        end
    end
endmodule

// File: rtl/byte_sar_unit.sv
module byte_sar_unit
    import byte_sar_pkg::*;
#(
    parameter int         LANES        = 4,
    parameter int         LANE_W       = 8,
    parameter int         OPW          = 32,
    parameter bit         REG_OUT      = 1'b1,
    parameter logic [5:0] FORM_A_MAJOR = 6'b000000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    valid_in,
    input  logic [LANES*LANE_W-1:0] src_word,
    input  logic [OPW-1:0]          amt_word,
    input  logic                    round_mode,
    input  logic [31:0]             instr_word,
    output logic                    valid_out,
    output logic [2*LANES*LANE_W-1:0] result,
    output logic                    dec_plain,
    output logic                    dec_round,
    output logic                    dec_unknown
);
    localparam int DW  = LANES * LANE_W;
    localparam int SHW = $clog2(LANE_W);

    typedef struct packed {
        logic          vld;
        logic [2*DW-1:0] data;
    } out_st_t;

    logic [SHW-1:0] amt;
    logic [DW-1:0]  lanes_packed;
    logic [LANES-1:0] lane_neg;
    logic [2*DW-1:0] packed_res;
    dec_kind_t      kind;

    assign amt = amt_word[SHW-1:0];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        byte_sar_lane #(.W(LANE_W), .SHW(SHW)) u_lane (
            .lane_in  (src_word[g*LANE_W +: LANE_W]),
            .amt      (amt),
            .rnd      (round_mode),
            .lane_out (lanes_packed[g*LANE_W +: LANE_W]),
            .lane_neg (lane_neg[g])
        );
    end

    assign packed_res = {{DW{lane_neg[LANES-1]}}, lanes_packed};

    if (REG_OUT) begin : g_reg
        out_st_t st_d, st_q;

        always_comb begin
            st_d     = st_q;
            st_d.vld = 1'b0;
            if (valid_in) begin
                st_d.vld  = 1'b1;
                st_d.data = packed_res;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end

        assign valid_out = st_q.vld;
        assign result    = st_q.data;
    end else begin : g_comb
        assign valid_out = valid_in;
        assign result    = packed_res;
    end

    byte_sar_decode #(.FORM_A_MAJOR(FORM_A_MAJOR)) u_dec (
        .instr (instr_word),
        .kind  (kind)
    );

    assign dec_plain   = (kind == DK_PLAIN);
    assign dec_round   = (kind == DK_ROUND);
    assign dec_unknown = (kind == DK_NONE);
endmodule

// File: rtl/byte_sar_chk.sv
module byte_sar_chk #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    parameter int OPW    = 32,
    parameter bit LAT    = 1'b1
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      valid_in,
    input logic [LANES*LANE_W-1:0]   src_word,
    input logic [OPW-1:0]            amt_word,
    input logic                      round_mode,
    input logic                      valid_out,
    input logic [2*LANES*LANE_W-1:0] result,
    input logic                      dec_plain,
    input logic                      dec_round,
    input logic                      dec_unknown
);
    localparam int DW  = LANES * LANE_W;
    localparam int SHW = $clog2(LANE_W);

    AST_DEC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({dec_plain, dec_round, dec_unknown}) == 1); // R9

    AST_SIGN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |-> (result[2*DW-1:DW] == {DW{result[DW-1]}})); // R5

    if (LAT) begin : g_lat
        AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
            valid_in |=> valid_out); // R6
        AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
            !valid_in |=> (!valid_out && $stable(result))); // R6
        AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_in && amt_word[SHW-1:0] == '0) |=>
            (result[DW-1:0] == $past(src_word))); // R4
        AST_TRUNC_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_in && !round_mode) |=>
            (result[DW-1] == $past(src_word[DW-1]))); // R1
    end else begin : g_nolat
        AST_VALID_SAME: assert property (@(posedge clk) disable iff (!rst_n)
            valid_out == valid_in); // R6
        AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_in && amt_word[SHW-1:0] == '0) |->
            (result[DW-1:0] == src_word)); // R4
        AST_TRUNC_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_in && !round_mode) |->
            (result[DW-1] == src_word[DW-1])); // R1
    end
endmodule

bind byte_sar_unit byte_sar_chk #(
    .LANES(LANES), .LANE_W(LANE_W), .OPW(OPW), .LAT(REG_OUT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .src_word(src_word),
    .amt_word(amt_word), .round_mode(round_mode), .valid_out(valid_out),
    .result(result), .dec_plain(dec_plain), .dec_round(dec_round),
    .dec_unknown(dec_unknown)
);

// File: tb/sim_byte_sar_unit.sv
`timescale 1ns/1ps
module sim_byte_sar_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic [31:0] src_word = '0;
    logic [31:0] amt_word = '0;
    logic        round_mode = 1'b0;
    logic [31:0] instr_word = '0;
    logic        valid_out;
    logic [63:0] result;
    logic        dec_plain, dec_round, dec_unknown;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [31:0] seed = 32'h1234_5678;

    always #2 clk = ~clk;

    byte_sar_unit u0 (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .src_word(src_word),
        .amt_word(amt_word), .round_mode(round_mode), .instr_word(instr_word),
        .valid_out(valid_out), .result(result), .dec_plain(dec_plain),
        .dec_round(dec_round), .dec_unknown(dec_unknown)
    );

    function automatic logic [31:0] nxt(logic [31:0] s);
        return s * 32'd1664525 + 32'd1013904223;
    endfunction

    function automatic logic [63:0] model(logic [31:0] s, int k, logic r);
        logic [31:0] lo;
        logic        neg;
        int          v, q;
        lo  = '0;
        neg = 1'b0;
        for (int l = 0; l < 4; l++) begin
            v = int'($signed(s[8*l +: 8]));
            if (r && k != 0) q = (v + (1 << (k - 1))) >>> k;
            else             q = v >>> k;
            lo[8*l +: 8] = q[7:0];
            if (l == 3) neg = (q < 0);
        end
        return {{32{neg}}, lo};
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(logic [31:0] s, int k, logic r);
        logic [63:0] exp;
        string tag;
        seed = nxt(seed);
        src_word   = s;
        amt_word   = {seed[31:3], 3'(k)};
        round_mode = r;
        valid_in   = 1'b1;
        exp = model(s, k, r);
        @(posedge clk);
        @(negedge clk);
        if (k == 0)  tag = "R4 zero-pass";
        else if (r)  tag = "R3 round R2";
        else         tag = "R1 trunc R2";
        chk(tag, {result[31:0], 31'd0, valid_out}, {exp[31:0], 31'd0, 1'b1});
        chk("R5 fill", {32'd0, result[63:32]}, {32'd0, exp[63:32]});
    endtask

    task automatic dec_chk(string tag, logic [31:0] w, logic [2:0] exp);
        instr_word = w;
        #1;
        chk(tag, {61'd0, dec_plain, dec_round, dec_unknown}, {61'd0, exp});
    endtask

    initial begin
        logic [31:0] words [8];
        logic [63:0] held;
        words[0] = 32'h807F_FF00;
        words[1] = 32'hFF00_807F;
        words[2] = 32'h7F80_00FF;
        words[3] = 32'h0180_7EFE;
        for (int i = 4; i < 8; i++) begin
            seed = nxt(seed);
            words[i] = seed;
        end
        repeat (3) @(negedge clk);
        chk("R10 reset", {result, 63'd0, valid_out}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 idle", {63'd0, valid_out}, '0);

        for (int r = 0; r < 2; r++)
            for (int k = 0; k < 8; k++)
                for (int i = 0; i < 8; i++)
                    run_op(words[i], k, r[0]);

        // named corner cases
        run_op(32'h0000_007F, 1, 1'b1);
        chk("R3 7F>>1 round", {56'd0, result[7:0]}, 64'h40);
        run_op(32'h8000_0000, 7, 1'b0);
        chk("R1 80>>7 trunc", {56'd0, result[31:24]}, 64'hFF);

        // hold when valid low
        held = result;
        valid_in = 1'b0;
        src_word = 32'hDEAD_BEEF;
        @(posedge clk);
        @(negedge clk);
        chk("R6 hold", {result, 63'd0, valid_out}, {held, 64'd0});

        // decode
        for (int i = 0; i < 4; i++) begin
            seed = nxt(seed);
            dec_chk("R7 A plain", {6'b000000, seed[20:6], 11'b00111001101}, 3'b100);
            dec_chk("R7 A round", {6'b000000, seed[20:6], 11'b10111001101}, 3'b010);
            dec_chk("R8 B plain", {6'b011111, seed[25:11], 5'b00110, 6'b010011}, 3'b100);
            dec_chk("R8 B round", {6'b011111, seed[25:11], 5'b00111, 6'b010011}, 3'b010);
            dec_chk("R9 B func", {6'b011111, seed[25:11], 5'b00110, 6'b010010}, 3'b001);
            dec_chk("R9 B sub", {6'b011111, seed[25:11], 5'b00101, 6'b010011}, 3'b001);
            dec_chk("R9 A minor", {6'b000000, seed[20:6], 11'b00111001100}, 3'b001);
            dec_chk("R9 A major", {6'b000001, seed[20:6], 11'b00111001101}, 3'b001);
        end
        dec_chk("R9 zero", 32'h0, 3'b001);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule